// File: doc/BRIEF.md
# Deconvolution Combiner for a Pulse-Height Filter

This block produces the deconvolved, differentiated pulse signal for a digital pulse-height filter. Each input sample carries two values taken over the same window of M samples: the signed difference x[n] − x[n−M] and the unsigned 24-bit moving sum of that window. The block multiplies the moving sum by a programmable decay coefficient and adds the scaled product to the difference. The result is a signed 24-bit word with 17 integer bits and 7 fractional bits.

The decay coefficient is an unsigned 24-bit fraction whose value is the real coefficient times 2^24. The real coefficient is roughly (1 − e^(−M/τ)) divided by the window length. Software writes it in two parts through one 16-bit configuration port. A low-half write loads coefficient bits 15:0. A high-part write loads coefficient bits 23:16 from the low byte of the configuration word. The upper byte of that word belongs to another setting and this block ignores it. The multiplier is pipelined, and the difference travels through a matching delay line. The two operands of the final adder therefore always come from the same sample.

Top module: `mwdCombiner`

## Requirements
- R1: While reset is active, outValid is 0, outResult is 0 and the coefficient is 0. Reset is asynchronous and active low.
- R2: When coefLoWr is 1 on a rising edge, coefficient bits 15:0 take the value of cfgWord.
- R3: When coefHiWr is 1 on a rising edge, coefficient bits 23:16 take cfgWord bits 7:0. cfgWord bits 15:8 have no effect on the coefficient.
- R4: The scaled term is bits 38:16 of the 48-bit unsigned product inSum × coefficient, placed in bits 22:0. Bit 23 of the scaled term is always 0.
- R5: The 17-bit two's-complement inDiff occupies result bits 23:7, and bits 6:0 of the aligned difference are zero. With a zero coefficient, outResult equals inDiff × 128.
- R6: outResult is the aligned difference plus the scaled term, taken modulo 2^24 and read as a 17.7 two's-complement value.
- R7: A sample accepted with inValid=1 on a rising edge appears with outValid=1 after the fifth rising edge, counting the accepting edge as the first. This latency is MUL_LAT+1 with MUL_LAT=4. outValid is 1 only for such samples.
- R8: While outValid is 0, outResult holds its previous value.
- R9: A sample uses the coefficient held before its accepting edge. A coefficient write on that same edge, or on any later edge, does not change a sample that is already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coefLoWr | input | 1 | Load coefficient bits 15:0 from cfgWord |
| coefHiWr | input | 1 | Load coefficient bits 23:16 from cfgWord[7:0] |
| cfgWord | input | 16 | Configuration write data |
| inValid | input | 1 | Input sample strobe |
| inDiff | input | 17 | Signed window difference x[n] − x[n−M] |
| inSum | input | 24 | Unsigned moving sum over the window |
| outValid | output | 1 | Result strobe |
| outResult | output | 24 | Signed 17.7 combined result |

## Verification
The bench drives a full-scale sum and a full-scale coefficient. A design that took the wrong product slice, or let bit 23 of the scaled term through, would give a value other than 0x7FFE00. A difference of −1 with a zero coefficient must give 0xFFFF80. A result that is not sign-extended correctly, or that is shifted by the wrong amount, shows up there. A maximum positive difference plus a large scaled term must wrap modulo 2^24.

A write to the high part with a non-zero upper byte catches a design that reads the wrong byte. A coefficient change on the same edge as a valid sample catches a design that mixes old and new coefficients within one sample. A gapped stream, checked on every cycle against a behavioural model, catches a difference delay that does not match the multiplier latency and a result that moves while outValid is 0. A reset in the middle of the stream must flush every sample in flight.

// File: rtl/mwdPkg.sv
package mwdPkg;
  // configuration-load strobes passed from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
  } cfgStrobe_t;
endpackage

// File: rtl/mwdCtrl.sv
module mwdCtrl
  import mwdPkg::*;
#(
  parameter int LAT = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           coefLoWr,
  input  logic           coefHiWr,
  output cfgStrobe_t     strobe,
  output logic [LAT-1:0] stageEn,
  output logic           outValid
);
  logic [LAT-1:0] vReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vReg <= '0;
    else       vReg <= {vReg[LAT-2:0], inValid};
  end

  always_comb begin
    strobe.loadLo = coefLoWr;
    strobe.loadHi = coefHiWr;
    stageEn       = {vReg[LAT-2:0], inValid};
  end

  assign outValid = vReg[LAT-1];
endmodule

// File: rtl/mwdDatapath.sv
module mwdDatapath
  import mwdPkg::*;
#(
  parameter int MUL_LAT = 4,
  parameter int DIFF_W  = 17,
  parameter int SUM_W   = 24,
  parameter int COEF_W  = 24,
  parameter int CFG_W   = 16,
  parameter int OUT_W   = 24,
  parameter int PROD_LO = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobe_t               strobe,
  input  logic [MUL_LAT:0]         stageEn,
  input  logic [CFG_W-1:0]         cfgWord,
  input  logic signed [DIFF_W-1:0] inDiff,
  input  logic [SUM_W-1:0]         inSum,
  output logic [COEF_W-1:0]        coefVal,
  output logic [OUT_W-1:0]         outResult
);
  localparam int PROD_W  = SUM_W + COEF_W;
  localparam int HI_W    = COEF_W - CFG_W;
  localparam int FRAC_W  = OUT_W - DIFF_W;
  localparam int SCALE_W = OUT_W - 1;
  localparam int PSTAGES = MUL_LAT - 1;

  logic [COEF_W-1:0] coefReg;
  logic [SUM_W-1:0]  opSum;
  logic [COEF_W-1:0] opCoef;
  logic [PROD_W-1:0] prodPipe [PSTAGES];
  logic [DIFF_W-1:0] diffPipe [MUL_LAT];
  logic [OUT_W-1:0]  scaledTerm;
  logic [OUT_W-1:0]  diffAligned;
  logic [OUT_W-1:0]  sumNext;

  // coefficient halves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefReg <= '0;
    end else begin
      if (strobe.loadLo) coefReg[CFG_W-1:0]      <= cfgWord;
      if (strobe.loadHi) coefReg[COEF_W-1:CFG_W] <= cfgWord[HI_W-1:0];
    end
  end

  // multiplier pipeline and matched difference delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opSum     <= '0;
      opCoef    <= '0;
      outResult <= '0;
      for (int j = 0; j < PSTAGES; j++) prodPipe[j] <= '0;
      for (int j = 0; j < MUL_LAT; j++) diffPipe[j] <= '0;
    end else begin
      if (stageEn[0]) begin
        opSum       <= inSum;
        opCoef      <= coefReg;
        diffPipe[0] <= inDiff;
      end
      if (stageEn[1]) prodPipe[0] <= opSum * opCoef;
      for (int j = 1; j < PSTAGES; j++)
        if (stageEn[j+1]) prodPipe[j] <= prodPipe[j-1];
      for (int j = 1; j < MUL_LAT; j++)
        if (stageEn[j]) diffPipe[j] <= diffPipe[j-1];
      if (stageEn[MUL_LAT]) outResult <= sumNext;
    end
  end

  always_comb begin
    scaledTerm  = {1'b0, prodPipe[PSTAGES-1][PROD_LO+SCALE_W-1:PROD_LO]};
    diffAligned = {diffPipe[MUL_LAT-1], {FRAC_W{1'b0}}};
    sumNext     = diffAligned + scaledTerm;
  end

  assign coefVal = coefReg;
endmodule

// File: rtl/mwdCombiner.sv
module mwdCombiner
  import mwdPkg::*;
#(
  parameter int MUL_LAT = 4,
  parameter int DIFF_W  = 17,
  parameter int SUM_W   = 24,
  parameter int COEF_W  = 24,
  parameter int CFG_W   = 16,
  parameter int OUT_W   = 24,
  parameter int PROD_LO = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coefLoWr,
  input  logic              coefHiWr,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              inValid,
  input  logic [DIFF_W-1:0] inDiff,
  input  logic [SUM_W-1:0]  inSum,
  output logic              outValid,
  output logic [OUT_W-1:0]  outResult
);
  localparam int LAT = MUL_LAT + 1;

  cfgStrobe_t        strobe;
  logic [LAT-1:0]    stageEn;
  logic [COEF_W-1:0] coefVal;

  mwdCtrl #(.LAT(LAT)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .coefLoWr(coefLoWr), .coefHiWr(coefHiWr),
    .strobe(strobe), .stageEn(stageEn), .outValid(outValid)
  );

  mwdDatapath #(
    .MUL_LAT(MUL_LAT), .DIFF_W(DIFF_W), .SUM_W(SUM_W), .COEF_W(COEF_W),
    .CFG_W(CFG_W), .OUT_W(OUT_W), .PROD_LO(PROD_LO)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stageEn(stageEn),
    .cfgWord(cfgWord), .inDiff(inDiff), .inSum(inSum),
    .coefVal(coefVal), .outResult(outResult)
  );
endmodule

// File: rtl/mwdCombinerChk.sv
module mwdCombinerChk #(
  parameter int LAT    = 5,
  parameter int COEF_W = 24,
  parameter int CFG_W  = 16,
  parameter int OUT_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              coefLoWr,
  input logic              coefHiWr,
  input logic [CFG_W-1:0]  cfgWord,
  input logic              inValid,
  input logic              outValid,
  input logic [OUT_W-1:0]  outResult,
  input logic [COEF_W-1:0] coefVal
);
  localparam int HI_W = COEF_W - CFG_W;

  logic [LAT-1:0] seenValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenValid <= '0;
    else       seenValid <= {seenValid[LAT-2:0], inValid};
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> !outValid); // R1
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    coefLoWr |=> coefVal[CFG_W-1:0] == $past(cfgWord)); // R2
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    coefHiWr |=> coefVal[COEF_W-1:CFG_W] == $past(cfgWord[HI_W-1:0])); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == seenValid[LAT-1]); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outResult)); // R8
  AST_COEF_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!coefLoWr && !coefHiWr) |=> $stable(coefVal)); // R9
endmodule

bind mwdCombiner mwdCombinerChk #(
  .LAT(MUL_LAT + 1), .COEF_W(COEF_W), .CFG_W(CFG_W), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .coefLoWr(coefLoWr), .coefHiWr(coefHiWr),
  .cfgWord(cfgWord), .inValid(inValid), .outValid(outValid),
  .outResult(outResult), .coefVal(coefVal)
);

// File: tb/mwdCombiner_tb_top.sv
module mwdCombiner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MUL_LAT    = 4;
  localparam int LAT        = MUL_LAT + 1;

  logic        clk = 0;
  logic        rstN = 0;
  logic        coefLoWr = 0, coefHiWr = 0, inValid = 0;
  logic [15:0] cfgWord = 0;
  logic [16:0] inDiff = 0;
  logic [23:0] inSum = 0;
  logic        outValid;
  logic [23:0] outResult;

  int errors = 0, checks = 0, cycles = 0;
  string phase = "R1 reset";

  // behavioural reference state
  bit          vP [LAT];
  logic [23:0] rP [LAT];
  logic [23:0] lastR = 0;
  logic [23:0] mCoef = 0;

  mwdCombiner dut_i (
    .clk(clk), .rstN(rstN), .coefLoWr(coefLoWr), .coefHiWr(coefHiWr),
    .cfgWord(cfgWord), .inValid(inValid), .inDiff(inDiff), .inSum(inSum),
    .outValid(outValid), .outResult(outResult)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] refCalc(logic [16:0] d, logic [23:0] s, logic [23:0] c);
    longint p, sc, da;
    p  = longint'(s) * longint'(c);
    sc = (p >>> 16) & 64'h7FFFFF;
    da = longint'($signed(d)) * 128;
    return 24'((da + sc) & 64'hFFFFFF);
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // model update on the active edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) begin vP[i] = 0; rP[i] = 0; end
      lastR = 0;
      mCoef = 0;
    end else begin
      for (int i = LAT-1; i > 0; i--) begin vP[i] = vP[i-1]; rP[i] = rP[i-1]; end
      vP[0] = inValid;
      rP[0] = refCalc(inDiff, inSum, mCoef);
      if (vP[LAT-1]) lastR = rP[LAT-1];
      if (coefLoWr) mCoef[15:0]  = cfgWord;
      if (coefHiWr) mCoef[23:16] = cfgWord[7:0];
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    check({phase, " R7 valid"}, {23'd0, outValid}, {23'd0, vP[LAT-1]});
    if (vP[LAT-1]) check({phase, " R6 result"}, outResult, lastR);
    else           check({phase, " R8 hold"}, outResult, lastR);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 0; coefLoWr = 0; coefHiWr = 0;
    end
  endtask

  task automatic sample(logic [16:0] d, logic [23:0] s);
    @(negedge clk);
    coefLoWr = 0; coefHiWr = 0;
    inValid = 1; inDiff = d; inSum = s;
  endtask

  task automatic writeCoef(bit hi, logic [15:0] w);
    @(negedge clk);
    inValid = 0;
    coefLoWr = !hi; coefHiWr = hi; cfgWord = w;
  endtask

  // one sample, then wait for its result and compare with a hand value
  task automatic directed(string req, logic [16:0] d, logic [23:0] s, logic [23:0] exp);
    sample(d, s);
    idle(1);
    while (!outValid) @(negedge clk);
    check(req, outResult, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {23'd0, outValid}, 24'd0);
    check("R1 reset result", outResult, 24'd0);
    rstN = 1;
    idle(2);

    phase = "R5 zero coef";
    directed("R5 diff -1 zero coef", 17'h1FFFF, 24'hABCDEF, 24'hFFFF80);
    directed("R5 diff +5 zero coef", 17'd5, 24'hFFFFFF, 24'h000280);

    phase = "R2 low load";
    writeCoef(0, 16'h3C17);
    directed("R2 low half", 17'd0, 24'h010000, 24'h003C17);

    phase = "R3 high load";
    writeCoef(1, 16'hA512);
    directed("R3 high byte upper ignored", 17'd0, 24'h000100,
             refCalc(17'd0, 24'h000100, 24'h123C17));
    check("R3 expected value", refCalc(17'd0, 24'h000100, 24'h123C17), 24'h123C17 >> 8);

    phase = "R4 full scale";
    writeCoef(0, 16'hFFFF);
    writeCoef(1, 16'h00FF);
    directed("R4 slice and sign bit", 17'd0, 24'hFFFFFF, 24'h7FFE00);

    phase = "R6 wrap";
    directed("R6 wrap modulo", 17'h0FFFF, 24'hFFFFFF, 24'h7FFF80 + 24'h7FFE00);

    phase = "R7 R8 gapped stream";
    writeCoef(0, 16'h3C17);
    writeCoef(1, 16'h0000);
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 2) != 0) sample(17'($urandom), 24'($urandom));
      else idle(1);
    end
    idle(LAT + 2);

    phase = "R9 coef change in flight";
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      inValid = 1; inDiff = 17'($urandom); inSum = 24'($urandom);
      coefLoWr = (k % 3) == 0; coefHiWr = (k % 5) == 0; cfgWord = 16'($urandom);
    end
    idle(LAT + 2);

    phase = "R1 mid-run reset";
    for (int k = 0; k < 3; k++) sample(17'($urandom), 24'($urandom));
    @(negedge clk);
    rstN = 0; inValid = 0;
    @(negedge clk);
    check("R1 flush valid", {23'd0, outValid}, 24'd0);
    check("R1 flush result", outResult, 24'd0);
    rstN = 1;
    idle(LAT + 3);
    phase = "R1 after reset zero coef";
    directed("R1 coef cleared", 17'd3, 24'hFFFFFF, 24'h000180);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule